// File: doc/BRIEF.md
# Handshake Word Crossing Between Clock Domains

This block carries one multi-bit word at a time from a source clock domain to an unrelated destination clock domain. The word is never passed through synchronizers bit by bit. The source holds it in a register that does not change during the transfer. A single request line is synchronized into the destination domain. A single acknowledge line is synchronized back into the source domain. These two lines are the only points where the domains meet through synchronizers.

The default signalling is return-to-zero. The request rises, the acknowledge answers by rising, the request falls, and the acknowledge falls. The source is free again only after that last step. A parameter selects transition signalling instead. In that mode each word toggles the request once and is answered by one toggle of the acknowledge, with no return phase.

On the source side, a user pulses `send_i` with a word and watches `busy_o`. On the destination side, the received word appears on `data_o` together with a one-cycle `strobe_o`. Each domain has its own reset. Each reset is asserted asynchronously and released synchronously to its own clock.

Top module: `hs_cdc_xfer`

## Requirements
- R1: While either reset is held and after it is released, `busy_o`, `strobe_o` and `data_o` are all zero until the first word arrives.
- R2: `send_i` high at a source clock edge while `busy_o` is low starts a transfer of `data_i`, and `busy_o` is high from the following cycle.
- R3: `send_i` pulses that arrive while `busy_o` is high start no transfer and produce no strobe of their own.
- R4: Every accepted word is delivered exactly once, in order, with a `strobe_o` that is high for exactly one destination cycle.
- R5: `data_o` changes only in the cycle where `strobe_o` is high, and otherwise keeps the last delivered word.
- R6: In return-to-zero mode (`TWO_PHASE`=0) the request rises only while the synchronized acknowledge is low and falls only after it is high. `busy_o` returns low only after the word has been delivered.
- R7: In transition mode (`TWO_PHASE`=1) the request toggles only when the synchronized acknowledge equals it, and every word is delivered once with `busy_o` falling only after delivery.
- R8: Changes on `data_i` while `busy_o` is high do not alter the word being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain reset, active low, asynchronous assert |
| send_i | input | 1 | Request to transfer `data_i` |
| data_i | input | DATA_W | Word to transfer |
| busy_o | output | 1 | Transfer in progress; new sends ignored |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain reset, active low, asynchronous assert |
| data_o | output | DATA_W | Last received word |
| strobe_o | output | 1 | One-cycle pulse marking a new word on `data_o` |

## Verification
The hardest condition to reach is a send request, together with a changed input word, that arrives while a transfer is still waiting for its acknowledge. An ignored request has no trace at the ports except a missing or wrong delivery. The stimulus therefore fires a second `send_i` carrying the inverted word in the cycle right after each accepted send, and it leaves that word on `data_i` for the rest of the handshake. All 256 byte values are swept this way in both signalling modes, with unrelated clock periods. Each delivery is matched against the accepted sequence, and the source's release is checked to come only after delivery.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= {q_q[N-2:0], d_i};
  end

  assign q_o = q_q[N-1];
endmodule

// File: rtl/hs_src.sv
module hs_src
  import hs_cdc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter bit          TWO_PHASE   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  src_state_e        state_q;
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_s;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        SRC_IDLE: if (send_i) begin
          data_q  <= data_i;
          req_q   <= TWO_PHASE ? ~req_q : 1'b1;
          state_q <= SRC_WAIT_ACK;
        end
        SRC_WAIT_ACK: begin
          if (TWO_PHASE) begin
            if (ack_s == req_q) state_q <= SRC_IDLE;
          end else if (ack_s) begin
            req_q   <= 1'b0;
            state_q <= SRC_WAIT_REL;
          end
        end
        SRC_WAIT_REL: if (!ack_s) state_q <= SRC_IDLE;
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;
  assign busy_o = (state_q != SRC_IDLE);

  AST_SRC_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(data_q))); // R8

  AST_SRC_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && send_i) |=> (busy_o || !$stable(req_q) || $stable(data_q))); // R3

  generate
    if (TWO_PHASE) begin : g_tp_chk
      AST_SRC_TOGGLE_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(req_q) |-> ($past(ack_s) == $past(req_q))); // R7
    end else begin : g_fp_chk
      AST_SRC_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_q) |-> !ack_s); // R6
      AST_SRC_FALL_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(req_q) |-> ack_s); // R6
    end
  endgenerate
endmodule

// File: rtl/hs_dst.sv
module hs_dst #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          TWO_PHASE   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o
);
  logic              req_s;
  logic              ack_q;
  logic              take;
  logic              strobe_q;
  logic [DATA_W-1:0] data_q;

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // new word: toggle in transition mode, rising level in return-to-zero mode
  assign take = TWO_PHASE ? (req_s ^ ack_q) : (req_s & ~ack_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      ack_q    <= req_s;
      strobe_q <= take;
      if (take) data_q <= data_i;
    end
  end

  assign ack_o    = ack_q;
  assign data_o   = data_q;
  assign strobe_o = strobe_q;

  AST_DST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R4

  AST_DST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(data_o)); // R5

  AST_DST_STROBE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (ack_o == $past(req_s))); // R4
endmodule

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          TWO_PHASE   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o
);
  logic              src_rst_n;
  logic              dst_rst_n;
  logic              req;
  logic              ack;
  logic [DATA_W-1:0] xdata;

  // async assert, sync release per domain
  hs_sync #(.STAGES(SYNC_STAGES)) u_src_rst (
    .clk_i (src_clk_i),
    .rst_ni(src_rst_ni),
    .d_i   (1'b1),
    .q_o   (src_rst_n)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_dst_rst (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (1'b1),
    .q_o   (dst_rst_n)
  );

  hs_src #(
    .DATA_W     (DATA_W),
    .TWO_PHASE  (TWO_PHASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i (src_clk_i),
    .rst_ni(src_rst_n),
    .send_i(send_i),
    .data_i(data_i),
    .ack_i (ack),
    .req_o (req),
    .data_o(xdata),
    .busy_o(busy_o)
  );

  hs_dst #(
    .DATA_W     (DATA_W),
    .TWO_PHASE  (TWO_PHASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dst (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_n),
    .req_i   (req),
    .data_i  (xdata),
    .ack_o   (ack),
    .data_o  (data_o),
    .strobe_o(strobe_o)
  );
endmodule

// File: tb/tb_hs_cdc_xfer.sv
`timescale 1ns/1ps
module tb_hs_cdc_xfer;
  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;

  logic       send_f = 1'b0, send_t = 1'b0;
  logic [7:0] din_f = '0, din_t = '0;
  logic       busy_f, busy_t;
  logic [7:0] dout_f, dout_t;
  logic       stb_f, stb_t;

  int checks = 0;
  int fails  = 0;
  int tx_f = 0, rx_f = 0, tx_t = 0, rx_t = 0;
  logic [7:0] exp_f [0:255];
  logic [7:0] exp_t [0:255];
  logic       prev_stb_f = 1'b0, prev_stb_t = 1'b0;
  logic [7:0] last_f = '0, last_t = '0;
  bit         mon_on = 1'b0;

  always #4   src_clk = ~src_clk;
  always #6.7 dst_clk = ~dst_clk;

  hs_cdc_xfer #(.DATA_W(8), .TWO_PHASE(1'b0), .SYNC_STAGES(2)) dut (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .send_i(send_f), .data_i(din_f),
    .busy_o(busy_f), .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .data_o(dout_f), .strobe_o(stb_f));

  hs_cdc_xfer #(.DATA_W(8), .TWO_PHASE(1'b1), .SYNC_STAGES(2)) dut_tp (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .send_i(send_t), .data_i(din_t),
    .busy_o(busy_t), .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .data_o(dout_t), .strobe_o(stb_t));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // destination monitors: R4 order/once/pulse, R5 hold
  always @(negedge dst_clk) if (mon_on) begin
    if (stb_f) begin
      check(rx_f < tx_f && dout_f == exp_f[rx_f[7:0]], "R4 rtz word", int'(dout_f), int'(exp_f[rx_f[7:0]]));
      check(!prev_stb_f, "R4 rtz strobe width", 2, 1);
      rx_f++;
      last_f = dout_f;
    end else begin
      check(dout_f == last_f, "R5 rtz hold", int'(dout_f), int'(last_f));
    end
    prev_stb_f = stb_f;
    if (stb_t) begin
      check(rx_t < tx_t && dout_t == exp_t[rx_t[7:0]], "R7 tr word", int'(dout_t), int'(exp_t[rx_t[7:0]]));
      check(!prev_stb_t, "R4 tr strobe width", 2, 1);
      rx_t++;
      last_t = dout_t;
    end else begin
      check(dout_t == last_t, "R5 tr hold", int'(dout_t), int'(last_t));
    end
    prev_stb_t = stb_t;
  end

  task automatic xfer(input bit tp, input logic [7:0] w);
    @(negedge src_clk);
    if (tp) begin send_t = 1'b1; din_t = w; exp_t[tx_t[7:0]] = w; tx_t++; end
    else    begin send_f = 1'b1; din_f = w; exp_f[tx_f[7:0]] = w; tx_f++; end
    @(negedge src_clk);
    // R2: busy one cycle after accepted send
    if (tp) check(busy_t, "R2 tr busy", int'(busy_t), 1);
    else    check(busy_f, "R2 rtz busy", int'(busy_f), 1);
    // R3/R8: second send with a new word while busy
    if (tp) din_t = ~w; else din_f = ~w;
    @(negedge src_clk);
    if (tp) send_t = 1'b0; else send_f = 1'b0;
    if (tp) begin while (busy_t) @(negedge src_clk); end
    else    begin while (busy_f) @(negedge src_clk); end
    // R6/R7: release only after delivery
    if (tp) check(rx_t == tx_t, "R7 tr release after delivery", rx_t, tx_t);
    else    check(rx_f == tx_f, "R6 rtz release after delivery", rx_f, tx_f);
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", rx_f + rx_t, 512);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge src_clk);
    // R1: outputs quiet during reset
    check(!busy_f && !busy_t, "R1 busy in reset", int'({busy_f, busy_t}), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (10) @(negedge dst_clk);
    check(!busy_f && !busy_t, "R1 busy after reset", int'({busy_f, busy_t}), 0);
    check(!stb_f && !stb_t, "R1 strobe after reset", int'({stb_f, stb_t}), 0);
    check(dout_f == 8'h00 && dout_t == 8'h00, "R1 data after reset", int'({dout_f, dout_t}), 0);
    mon_on = 1'b1;
    for (int i = 0; i < 256; i++) xfer(1'b0, 8'((i * 37 + 11) & 255));
    for (int i = 0; i < 256; i++) xfer(1'b1, 8'((i * 59 + 3) & 255));
    repeat (20) @(negedge dst_clk);
    // R3: ignored sends produced no extra deliveries
    check(rx_f == 256, "R3 rtz delivery count", rx_f, 256);
    check(rx_t == 256, "R3 tr delivery count", rx_t, 256);
    // R8: last delivered word is the accepted one, not the later data_i
    check(dout_f == exp_f[255], "R8 rtz final word", int'(dout_f), int'(exp_f[255]));
    check(dout_t == exp_t[255], "R8 tr final word", int'(dout_t), int'(exp_t[255]));
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule